// File: doc/BRIEF.md
# PLL Factor Search Engine

This block picks the three integer settings of a phase-locked loop: a reference divider R, a feedback multiplier F and an output divider OD. With them the loop produces fin·F/(R·OD), and the block makes that as close as it can to a requested frequency. A single start pulse hands over the reference frequency and the wanted output frequency, both in Hz as 32-bit unsigned numbers. The block then tests one candidate per clock cycle. It reports the chosen R, F and OD, the remaining deviation, a one-cycle completion pulse and an invalid flag.

The request is screened before the search begins. A candidate counts only if it respects the reference-divider limit and keeps the oscillator frequency fin·F/R inside its allowed window. The comparisons are made with products of integers, so no divider is needed anywhere. Writing the result into the loop's control register is left to the logic around the block.

Top module: `pll_factor_search`

## Requirements
- R1: After reset, done_o and bad_o are 0, and r_o, od_o, f_o and dev_o are all 0.
- R2: A request whose target lies below 21 250 000 or above 1 750 000 000 is refused. In that case done_o and bad_o go high on the cycle after the start edge, and r_o, od_o, f_o and dev_o read 0.
- R3: A request whose reference lies below 13 300 000 or above 1 750 000 000 is refused in the same way as R2.
- R4: A request is refused in the same way as R2 when the target is more than 64 times the reference, or when 256 times the target is less than the reference.
- R5: A candidate is usable only if all of the following hold: R·13 300 000 ≤ fin, fin·F ≥ 340 000 000·R, and fin·F ≤ 1 750 000 000·R.
- R6: Among usable candidates, the reported one minimises |fin·F/(R·OD) − target|. Candidates are visited with R ascending outermost, OD in the middle and F innermost, each starting at 1. On a tie, the earliest candidate visited is kept.
- R7: dev_o equals |fin·F − target·R·OD| for the reported candidate, which is the frequency error scaled by R·OD.
- R8: The k-th candidate visited is examined at the k-th clock edge after the start edge. The search stops at the first usable candidate with zero deviation, and otherwise runs through all R_MAX·OD_MAX·F_MAX candidates. done_o rises after the edge that examines the last candidate looked at.
- R9: If no candidate is usable, bad_o is raised together with done_o, and r_o, od_o, f_o and dev_o read 0.
- R10: done_o is high for exactly one cycle. bad_o changes only together with done_o. Results stay unchanged until the next search is accepted.
- R11: A start pulse that arrives while a search is running is ignored and does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a search when idle; its request values are captured at this edge |
| fin_i | input | 32 | Reference frequency in Hz |
| fout_i | input | 32 | Target output frequency in Hz |
| done_o | output | 1 | One-cycle completion pulse |
| bad_o | output | 1 | Request or search produced no valid setting |
| r_o | output | $clog2(R_MAX+1) | Chosen reference divider |
| od_o | output | $clog2(OD_MAX+1) | Chosen output divider |
| f_o | output | $clog2(F_MAX+1) | Chosen feedback multiplier |
| dev_o | output | 32+max(RW+OW,FW) | Deviation times R·OD |

## Verification
The bench builds the block with R_MAX=4, OD_MAX=4 and F_MAX=16, which gives 256 candidates per search and keeps every frequency limit at its default. At that size a brute-force model in the bench can replay the complete visiting order for each request. That makes it possible to compare the chosen factors, the deviation and the exact cycle of completion across a sweep of several references and dozens of targets. The reduced F range also makes low references fail every oscillator check, so the path where no candidate survives can be reached.

// File: rtl/pll_factor_search.sv
module pll_factor_search #(
  parameter int unsigned R_MAX    = 16,
  parameter int unsigned OD_MAX   = 16,
  parameter int unsigned F_MAX    = 64,
  parameter int unsigned MAX_MUL  = 64,
  parameter int unsigned MAX_DIV  = 256,
  parameter int unsigned FIN_MIN  = 13_300_000,
  parameter int unsigned FIN_MAX  = 1_750_000_000,
  parameter int unsigned FOUT_MIN = 21_250_000,
  parameter int unsigned FOUT_MAX = 1_750_000_000,
  parameter int unsigned VCO_MIN  = 340_000_000,
  parameter int unsigned VCO_MAX  = 1_750_000_000,
  localparam int RW = $clog2(R_MAX + 1),
  localparam int OW = $clog2(OD_MAX + 1),
  localparam int FW = $clog2(F_MAX + 1),
  localparam int DW = 32 + ((RW + OW > FW) ? RW + OW : FW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [31:0]   fin_i,
  input  logic [31:0]   fout_i,
  output logic          done_o,
  output logic          bad_o,
  output logic [RW-1:0] r_o,
  output logic [OW-1:0] od_o,
  output logic [FW-1:0] f_o,
  output logic [DW-1:0] dev_o
);

  logic          busy, found;
  logic [31:0]   fin_q, tgt_q;
  logic [RW-1:0] rc;
  logic [OW-1:0] oc;
  logic [FW-1:0] fc;

  logic [63:0] in_f, den, tgt_d, dev, best_den;
  logic r_ok, vco_ok, cand_ok, better, take, hit, last, finish, req_ok;

  assign in_f    = 64'(fin_q) * 64'(fc);
  assign den     = 64'(rc) * 64'(oc);
  assign tgt_d   = 64'(tgt_q) * den;
  assign dev     = (in_f > tgt_d) ? in_f - tgt_d : tgt_d - in_f;
  assign r_ok    = 64'(rc) * 64'(FIN_MIN) <= 64'(fin_q);
  assign vco_ok  = (in_f >= 64'(rc) * 64'(VCO_MIN)) && (in_f <= 64'(rc) * 64'(VCO_MAX));
  assign cand_ok = r_ok && vco_ok;
  assign best_den = 64'(r_o) * 64'(od_o);
  assign better  = !found || (dev * best_den < 64'(dev_o) * den);
  assign take    = busy && cand_ok && better;
  assign hit     = busy && cand_ok && (dev == 64'd0);
  assign last    = (rc == RW'(R_MAX)) && (oc == OW'(OD_MAX)) && (fc == FW'(F_MAX));
  assign finish  = busy && (hit || last);

  assign req_ok = (fout_i >= FOUT_MIN) && (fout_i <= FOUT_MAX) &&
                  (fin_i >= FIN_MIN) && (fin_i <= FIN_MAX) &&
                  (64'(fout_i) <= 64'(fin_i) * 64'(MAX_MUL)) &&
                  (64'(fout_i) * 64'(MAX_DIV) >= 64'(fin_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      found  <= 1'b0;
      fin_q  <= '0;
      tgt_q  <= '0;
      rc     <= '0;
      oc     <= '0;
      fc     <= '0;
      done_o <= 1'b0;
      bad_o  <= 1'b0;
      r_o    <= '0;
      od_o   <= '0;
      f_o    <= '0;
      dev_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          r_o   <= '0;
          od_o  <= '0;
          f_o   <= '0;
          dev_o <= '0;
          if (req_ok) begin
            busy  <= 1'b1;
            found <= 1'b0;
            fin_q <= fin_i;
            tgt_q <= fout_i;
            rc    <= RW'(1);
            oc    <= OW'(1);
            fc    <= FW'(1);
          end else begin
            done_o <= 1'b1;
            bad_o  <= 1'b1;
          end
        end
      end else begin
        if (take) begin
          r_o   <= rc;
          od_o  <= oc;
          f_o   <= fc;
          dev_o <= dev[DW-1:0];
          found <= 1'b1;
        end
        if (finish) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
          bad_o  <= !(found || take);
        end else if (fc == FW'(F_MAX)) begin
          fc <= FW'(1);
          if (oc == OW'(OD_MAX)) begin
            oc <= OW'(1);
            rc <= rc + RW'(1);
          end else begin
            oc <= oc + OW'(1);
          end
        end else begin
          fc <= fc + FW'(1);
        end
      end
    end
  end

  logic [63:0] res_inf;
  assign res_inf = 64'(fin_q) * 64'(f_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  bad_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bad_o) |-> done_o);

  // R9
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && bad_o) |-> (r_o == '0 && od_o == '0 && f_o == '0 && dev_o == '0));

  // R5
  limits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !bad_o) |-> (res_inf >= 64'(r_o) * 64'(VCO_MIN) &&
                            res_inf <= 64'(r_o) * 64'(VCO_MAX) &&
                            64'(r_o) * 64'(FIN_MIN) <= 64'(fin_q)));

  // R6
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !bad_o) |-> (r_o != '0 && od_o != '0 && f_o != '0 &&
                            r_o <= RW'(R_MAX) && od_o <= OW'(OD_MAX) && f_o <= FW'(F_MAX)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable({r_o, od_o, f_o, dev_o, bad_o}));

endmodule

// File: tb/pll_factor_search_test.sv
module pll_factor_search_test;
  localparam int unsigned RM = 4, OM = 4, FM = 16;
  localparam int RW = $clog2(RM + 1);
  localparam int OW = $clog2(OM + 1);
  localparam int FW = $clog2(FM + 1);
  localparam int DW = 32 + ((RW + OW > FW) ? RW + OW : FW);

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [31:0] fin_i = '0, fout_i = '0;
  logic done_o, bad_o;
  logic [RW-1:0] r_o;
  logic [OW-1:0] od_o;
  logic [FW-1:0] f_o;
  logic [DW-1:0] dev_o;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pll_factor_search #(.R_MAX(RM), .OD_MAX(OM), .F_MAX(FM)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fin_i(fin_i), .fout_i(fout_i),
    .done_o(done_o), .bad_o(bad_o), .r_o(r_o), .od_o(od_o), .f_o(f_o), .dev_o(dev_o));

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input longint fi, input longint fo, output bit eb,
                       output longint er, output longint eo, output longint ef,
                       output longint ed, output int ecyc);
    bit stop;
    int idx;
    longint inf, td, dv;
    eb = 1; er = 0; eo = 0; ef = 0; ed = 0; stop = 0; idx = 0;
    if (fo < 21_250_000 || fo > 1_750_000_000 || fi < 13_300_000 || fi > 1_750_000_000 ||
        fo > fi * 64 || fo * 256 < fi) begin
      ecyc = 1;
      return;
    end
    ecyc = RM * OM * FM + 1;
    for (int r = 1; r <= RM; r++)
      for (int o = 1; o <= OM; o++)
        for (int f = 1; f <= FM; f++) begin
          if (!stop) begin
            idx++;
            inf = fi * f;
            td  = fo * r * o;
            dv  = (inf > td) ? inf - td : td - inf;
            if (r * 64'd13_300_000 <= fi && inf >= r * 64'd340_000_000 &&
                inf <= r * 64'd1_750_000_000) begin
              if (eb || dv * er * eo < ed * r * o) begin
                er = r; eo = o; ef = f; ed = dv; eb = 0;
              end
              if (dv == 0) begin
                stop = 1;
                ecyc = idx + 1;
              end
            end
          end
        end
  endtask

  task automatic run(input longint fi, input longint fo, input bit poke, input string tag);
    bit eb;
    longint er, eo, ef, ed;
    int ecyc, cnt;
    model(fi, fo, eb, er, eo, ef, ed, ecyc);
    @(negedge clk);
    fin_i = 32'(fi); fout_i = 32'(fo); start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    cnt = 1;
    while (!done_o && cnt < 2000) begin
      if (poke && cnt == 3) begin
        start_i = 1'b1; fout_i = 32'(fo) ^ 32'h0005_a5a5;
      end else begin
        start_i = 1'b0; fout_i = 32'(fo);
      end
      @(posedge clk); #1;
      cnt++;
    end
    start_i = 1'b0;
    // R8 completion cycle
    check(cnt == ecyc, (tag == "R6") ? "R8" : tag, "cycles", cnt, ecyc);
    // R9 invalid flag
    check(bad_o == eb, tag, "bad", bad_o, eb);
    // R6 factors, R7 deviation
    check(r_o == er && od_o == eo && f_o == ef, tag, "r*1000+od*100+f",
          r_o * 1000 + od_o * 100 + f_o, er * 1000 + eo * 100 + ef);
    check(dev_o == ed, (tag == "R6") ? "R7" : tag, "dev", longint'(dev_o), ed);
    @(posedge clk); #1;
    // R10 single pulse and hold
    check(!done_o, "R10", "done after pulse", done_o, 0);
    check(r_o == er && f_o == ef && bad_o == eb, "R10", "hold f", f_o, ef);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(!done_o && !bad_o && r_o == 0 && od_o == 0 && f_o == 0 && dev_o == 0,
          "R1", "reset outputs", done_o + bad_o + r_o + f_o, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    run(27_000_000, 21_249_999, 0, "R2");
    run(27_000_000, 1_750_000_001, 0, "R2");
    run(13_299_999, 100_000_000, 0, "R3");
    run(1_750_000_001, 100_000_000, 0, "R3");
    run(13_300_000, 851_200_001, 0, "R4");
    run(13_300_000, 851_200_000, 0, "R4");
    run(20_000_000, 100_000_000, 0, "R9");
    run(50_000_000, 350_000_000, 0, "R8");
    run(27_000_000, 21_250_000, 0, "R5");
    run(27_000_000, 100_000_000, 1, "R11");

    foreach (fins[i]) begin
      for (int k = 0; k < 33; k++)
        run(fins[i], 21_250_000 + longint'(k) * 52_000_000, 0, "R6");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  longint fins[6] = '{13_300_000, 26_000_000, 27_000_000, 50_000_000, 100_000_000, 400_000_000};

endmodule